// File: doc/BRIEF.md
# Dataflow Execution Tile

This block is one cell of a two-dimensional execution array. At the start of a block of code, a fixed set of instructions is placed into the tile's local slots. Each slot keeps its own operand buffer. Operands arrive from the four mesh neighbours, or from the tile itself, and they arrive in any order. A slot issues as soon as every operand it needs is present. The set of slots therefore acts as a small distributed reservation station. Placement is fixed, but execution order is decided by when operands arrive.

Each result carries a target: a direction, a slot index and an operand index. A result whose target is inside the same tile goes straight back into that slot's operand buffer over an internal bypass. All other results leave through a registered output port with a valid/ready handshake. No result passes through a register file.

A flush input rolls the tile back to the block boundary. It empties all operand buffers and re-arms every slot, and the loaded instructions stay in place.

Top module: `dflow_tile`

## Requirements
- R1: After reset, `out_vld` and `err` are 0, and no slot issues until it has been loaded and fed.
- R2: A cycle with `ld_en` high stores opcode, target direction, target slot and target operand index into slot `ld_slot`, and clears that slot's operands and fired flag.
- R3: Operand port p (0=N, 1=E, 2=S, 3=W) with `in_vld[p]` writes `in_data` into operand A (`in_idx`=0) or operand B (`in_idx`=1) of slot `in_slot`. A slot whose operands are complete issues on the next clock edge, so an externally targeted result is visible one cycle after its last operand is stored.
- R4: Opcodes: 0 A+B, 1 A−B, 2 A&B, 3 A|B, 4 A^B, 5 A, 6 A shifted left by the low log2(DW) bits of B, 7 ~A. All arithmetic wraps at DW bits.
- R5: Opcodes 5 and 7 need only operand A and issue without operand B.
- R6: At most one slot issues per cycle. When several slots are ready, the lowest-numbered slot issues first.
- R7: A result whose target direction has bit 2 clear appears on the output port with `out_dir` equal to the two low direction bits, together with the target slot, the operand index and the data.
- R8: A result whose target direction has bit 2 set (code 4 = local) never appears on the output port. It is written into the target slot's operand in the issue cycle, and that slot can issue on the following edge.
- R9: While `out_vld` is high and `out_rdy` is low, all output fields hold steady and no slot issues, whether its target is local or external.
- R10: A slot issues at most once per block. An operand that arrives for a slot that has fired, or that is firing in that cycle, is discarded and sets `err`. `err` stays set until reset.
- R11: `flush` clears every operand valid bit, every fired flag and any held output in one cycle. It leaves the instructions loaded. Operands and loads presented in the flush cycle are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Load one instruction slot |
| ld_slot | input | 3 | Slot to load |
| ld_op | input | 3 | Opcode |
| ld_dir | input | 3 | Target direction (0 N, 1 E, 2 S, 3 W, 4 local) |
| ld_tslot | input | 3 | Target slot index |
| ld_tidx | input | 1 | Target operand index |
| in_vld | input | 4 | Operand valid, one per neighbour port |
| in_slot | input | 12 | Destination slot per port, 3 bits each, port p at bits 3p+2..3p |
| in_idx | input | 4 | Destination operand index per port |
| in_data | input | 64 | Operand data per port, 16 bits each, port p at bits 16p+15..16p |
| flush | input | 1 | Block rollback |
| out_vld | output | 1 | Result valid on output port |
| out_rdy | input | 1 | Mesh accepts the result |
| out_dir | output | 2 | Neighbour direction of result |
| out_slot | output | 3 | Consumer slot index |
| out_idx | output | 1 | Consumer operand index |
| out_data | output | 16 | Result value |
| err | output | 1 | Sticky late-operand flag |

## Verification
Operands are presented in several patterns, and each pattern separates a different behaviour:
- Both operands arrive in one cycle on two ports.
- A and B arrive in separate cycles.
- Two slots complete in the same cycle, which shows whether issue order follows slot number or arrival.
- A local-target producer feeds a consumer whose other operand is already waiting, which shows whether the bypass stays off the output port.

A stalled port with two results pending shows whether the hold and the pause both happen. An operand sent to an already-fired slot separates a silent drop from a re-issue. Operands straddling a flush show whether a partially filled slot is forgotten and whether fired slots become live again.

// File: rtl/dflow_pkg.sv
package dflow_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4,
    OP_MOV = 3'd5,
    OP_SHL = 3'd6,
    OP_NOT = 3'd7
  } op_e;

  localparam int NPORT = 4;

  localparam logic [2:0] DIR_N   = 3'd0;
  localparam logic [2:0] DIR_E   = 3'd1;
  localparam logic [2:0] DIR_S   = 3'd2;
  localparam logic [2:0] DIR_W   = 3'd3;
  localparam logic [2:0] DIR_LOC = 3'd4;

  // Single-operand opcodes do not wait for operand B.
  function automatic logic op_needs_b(input op_e op);
    return !(op == OP_MOV || op == OP_NOT);
  endfunction

endpackage

// File: rtl/dflow_alu.sv
module dflow_alu
  import dflow_pkg::*;
#(
  parameter int DW = 16
) (
  input  op_e           op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y
);
  localparam int SHW = $clog2(DW);

  always_comb begin
    unique case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_MOV:  y = a;
      OP_SHL:  y = a << b[SHW-1:0];
      OP_NOT:  y = ~a;
      default: y = a;
    endcase
  end
endmodule

// File: rtl/dflow_pick.sv
module dflow_pick #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          en,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] idx,
  output logic          any
);
  // Scan from the top so the lowest requester is the last one written.
  always_comb begin
    grant = '0;
    idx   = '0;
    any   = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (en && req[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        idx      = IW'(i);
        any      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dflow_slots.sv
module dflow_slots
  import dflow_pkg::*;
#(
  parameter int NSLOT = 8,
  parameter int DW    = 16,
  parameter int SW    = $clog2(NSLOT)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         flush,
  input  logic                         ld_en,
  input  logic [SW-1:0]                ld_slot,
  input  logic [2:0]                   ld_op,
  input  logic [2:0]                   ld_dir,
  input  logic [SW-1:0]                ld_tslot,
  input  logic                         ld_tidx,
  input  logic [NPORT-1:0]             in_vld,
  input  logic [NPORT*SW-1:0]          in_slot,
  input  logic [NPORT-1:0]             in_idx,
  input  logic [NPORT*DW-1:0]          in_data,
  input  logic                         byp_vld,
  input  logic [SW-1:0]                byp_slot,
  input  logic                         byp_idx,
  input  logic [DW-1:0]                byp_data,
  input  logic [NSLOT-1:0]             issue_oh,
  output logic [NSLOT-1:0]             ready,
  output logic [NSLOT-1:0][2:0]        s_op,
  output logic [NSLOT-1:0][2:0]        s_dir,
  output logic [NSLOT-1:0][SW-1:0]     s_tslot,
  output logic [NSLOT-1:0]             s_tidx,
  output logic [NSLOT-1:0][DW-1:0]     s_a,
  output logic [NSLOT-1:0][DW-1:0]     s_b,
  output logic                         late
);
  localparam int NSRC = NPORT + 1;

  // Neighbour ports and the local bypass as one list of write sources.
  logic [NSRC-1:0]         src_vld;
  logic [NSRC-1:0][SW-1:0] src_slot;
  logic [NSRC-1:0]         src_idx;
  logic [NSRC-1:0][DW-1:0] src_data;
  logic [NSLOT-1:0]        late_s;

  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      src_vld[p]  = in_vld[p];
      src_slot[p] = in_slot[p*SW +: SW];
      src_idx[p]  = in_idx[p];
      src_data[p] = in_data[p*DW +: DW];
    end
    src_vld[NPORT]  = byp_vld;
    src_slot[NPORT] = byp_slot;
    src_idx[NPORT]  = byp_idx;
    src_data[NPORT] = byp_data;
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic          ld_q, fire_q, va_q, vb_q, ti_q;
    logic [2:0]    op_q, dir_q;
    logic [SW-1:0] ts_q;
    logic [DW-1:0] a_q, b_q;
    logic          wa, wb, closed;
    logic [DW-1:0] da, db;

    always_comb begin
      wa = 1'b0;
      wb = 1'b0;
      da = a_q;
      db = b_q;
      for (int k = 0; k < NSRC; k++) begin
        if (src_vld[k] && src_slot[k] == SW'(s)) begin
          if (src_idx[k]) begin
            wb = 1'b1;
            db = src_data[k];
          end else begin
            wa = 1'b1;
            da = src_data[k];
          end
        end
      end
    end

    assign closed    = fire_q | issue_oh[s];
    assign late_s[s] = (wa | wb) & closed;

    always_ff @(posedge clk) begin
      if (rst) begin
        ld_q   <= 1'b0;
        fire_q <= 1'b0;
        va_q   <= 1'b0;
        vb_q   <= 1'b0;
      end else if (flush) begin
        fire_q <= 1'b0;
        va_q   <= 1'b0;
        vb_q   <= 1'b0;
      end else if (ld_en && ld_slot == SW'(s)) begin
        ld_q   <= 1'b1;
        fire_q <= 1'b0;
        va_q   <= 1'b0;
        vb_q   <= 1'b0;
        op_q   <= ld_op;
        dir_q  <= ld_dir;
        ts_q   <= ld_tslot;
        ti_q   <= ld_tidx;
      end else begin
        if (issue_oh[s]) fire_q <= 1'b1;
        if (wa && !closed) begin
          va_q <= 1'b1;
          a_q  <= da;
        end
        if (wb && !closed) begin
          vb_q <= 1'b1;
          b_q  <= db;
        end
      end
    end

    assign ready[s]   = ld_q & ~fire_q & va_q & (vb_q | ~op_needs_b(op_e'(op_q)));
    assign s_op[s]    = op_q;
    assign s_dir[s]   = dir_q;
    assign s_tslot[s] = ts_q;
    assign s_tidx[s]  = ti_q;
    assign s_a[s]     = a_q;
    assign s_b[s]     = b_q;
  end

  assign late = (|late_s) & ~flush;
endmodule

// File: rtl/dflow_tile.sv
module dflow_tile
  import dflow_pkg::*;
#(
  parameter int NSLOT = 8,
  parameter int DW    = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        ld_en,
  input  logic [$clog2(NSLOT)-1:0]    ld_slot,
  input  logic [2:0]                  ld_op,
  input  logic [2:0]                  ld_dir,
  input  logic [$clog2(NSLOT)-1:0]    ld_tslot,
  input  logic                        ld_tidx,
  input  logic [3:0]                  in_vld,
  input  logic [4*$clog2(NSLOT)-1:0]  in_slot,
  input  logic [3:0]                  in_idx,
  input  logic [4*DW-1:0]             in_data,
  input  logic                        flush,
  output logic                        out_vld,
  input  logic                        out_rdy,
  output logic [1:0]                  out_dir,
  output logic [$clog2(NSLOT)-1:0]    out_slot,
  output logic                        out_idx,
  output logic [DW-1:0]               out_data,
  output logic                        err
);
  localparam int SW = $clog2(NSLOT);

  logic [NSLOT-1:0]         ready, grant;
  logic [SW-1:0]            gidx;
  logic                     gany, can_go, local_tgt, byp_vld, late;
  logic [NSLOT-1:0][2:0]    s_op, s_dir;
  logic [NSLOT-1:0][SW-1:0] s_tslot;
  logic [NSLOT-1:0]         s_tidx;
  logic [NSLOT-1:0][DW-1:0] s_a, s_b;
  logic [2:0]               sel_dir;
  logic [DW-1:0]            res;

  assign can_go = (!out_vld || out_rdy) && !flush;

  dflow_pick #(.N(NSLOT), .IW(SW)) u_pick (
    .en(can_go), .req(ready), .grant(grant), .idx(gidx), .any(gany)
  );

  assign sel_dir   = s_dir[gidx];
  assign local_tgt = sel_dir[2];
  assign byp_vld   = gany && local_tgt;

  dflow_alu #(.DW(DW)) u_alu (
    .op(op_e'(s_op[gidx])), .a(s_a[gidx]), .b(s_b[gidx]), .y(res)
  );

  dflow_slots #(.NSLOT(NSLOT), .DW(DW), .SW(SW)) u_slots (
    .clk(clk), .rst(rst), .flush(flush),
    .ld_en(ld_en), .ld_slot(ld_slot), .ld_op(ld_op), .ld_dir(ld_dir),
    .ld_tslot(ld_tslot), .ld_tidx(ld_tidx),
    .in_vld(in_vld), .in_slot(in_slot), .in_idx(in_idx), .in_data(in_data),
    .byp_vld(byp_vld), .byp_slot(s_tslot[gidx]), .byp_idx(s_tidx[gidx]),
    .byp_data(res), .issue_oh(grant), .ready(ready),
    .s_op(s_op), .s_dir(s_dir), .s_tslot(s_tslot), .s_tidx(s_tidx),
    .s_a(s_a), .s_b(s_b), .late(late)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
    end else if (flush) begin
      out_vld <= 1'b0;
    end else if (gany && !local_tgt) begin
      out_vld  <= 1'b1;
      out_dir  <= sel_dir[1:0];
      out_slot <= s_tslot[gidx];
      out_idx  <= s_tidx[gidx];
      out_data <= res;
    end else if (out_rdy) begin
      out_vld <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       err <= 1'b0;
    else if (late) err <= 1'b1;
  end
endmodule

// File: rtl/dflow_tile_chk.sv
module dflow_tile_chk #(
  parameter int NSLOT = 8,
  parameter int DW    = 16,
  parameter int SW    = $clog2(NSLOT)
) (
  input logic             clk,
  input logic             rst,
  input logic             flush,
  input logic             out_vld,
  input logic             out_rdy,
  input logic [1:0]       out_dir,
  input logic [SW-1:0]    out_slot,
  input logic             out_idx,
  input logic [DW-1:0]    out_data,
  input logic             err,
  input logic [NSLOT-1:0] grant,
  input logic [NSLOT-1:0] ready
);
  // R9: a stalled result keeps every field
  a_r9_hold_fields: assert property (@(posedge clk) disable iff (rst)
    (out_vld && !out_rdy && !flush) |=> (out_vld && $stable(out_data) &&
      $stable(out_dir) && $stable(out_slot) && $stable(out_idx)));

  // R9: no slot issues behind a stalled result
  a_r9_no_issue: assert property (@(posedge clk) disable iff (rst)
    (out_vld && !out_rdy) |-> (grant == '0));

  // R6: one issue per cycle at most
  a_r6_single_issue: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  // R6: only a ready slot is granted
  a_r6_grant_ready: assert property (@(posedge clk) disable iff (rst)
    (grant != '0) |-> ((grant & ready) == grant));

  // R10: error flag is sticky
  a_r10_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  // R11: flush leaves nothing ready and nothing held
  a_r11_flush_empty: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!out_vld && ready == '0));
endmodule

bind dflow_tile dflow_tile_chk #(.NSLOT(NSLOT), .DW(DW), .SW(SW)) u_chk (
  .clk(clk), .rst(rst), .flush(flush), .out_vld(out_vld), .out_rdy(out_rdy),
  .out_dir(out_dir), .out_slot(out_slot), .out_idx(out_idx),
  .out_data(out_data), .err(err), .grant(grant), .ready(ready)
);

// File: tb/sim_dflow_tile.sv
`timescale 1ns/1ps
module sim_dflow_tile;
  logic        clk = 1'b0;
  logic        rst, ld_en, ld_tidx, flush, out_rdy;
  logic [2:0]  ld_slot, ld_op, ld_dir, ld_tslot;
  logic [3:0]  in_vld, in_idx;
  logic [11:0] in_slot;
  logic [63:0] in_data;
  logic        out_vld, out_idx, err;
  logic [1:0]  out_dir;
  logic [2:0]  out_slot;
  logic [15:0] out_data;

  typedef struct packed {
    logic [1:0]  dir;
    logic [2:0]  slot;
    logic        idx;
    logic [15:0] data;
  } item_t;

  item_t exp_q[$];
  string req_q[$];
  item_t got_i, exp_i;
  string req_s;
  int    n_chk = 0;
  int    n_fail = 0;

  always #10 clk = ~clk;

  dflow_tile u0 (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_slot(ld_slot), .ld_op(ld_op),
    .ld_dir(ld_dir), .ld_tslot(ld_tslot), .ld_tidx(ld_tidx),
    .in_vld(in_vld), .in_slot(in_slot), .in_idx(in_idx), .in_data(in_data),
    .flush(flush), .out_vld(out_vld), .out_rdy(out_rdy), .out_dir(out_dir),
    .out_slot(out_slot), .out_idx(out_idx), .out_data(out_data), .err(err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_alu(input int op, input logic [15:0] a,
                                          input logic [15:0] b);
    case (op)
      0: return a + b;
      1: return a - b;
      2: return a & b;
      3: return a | b;
      4: return a ^ b;
      5: return a;
      6: return a << b[3:0];
      default: return ~a;
    endcase
  endfunction

  // Scoreboard monitor: compares each accepted result with the queue head.
  always @(negedge clk) begin
    #2;
    if (!rst && out_vld && out_rdy) begin
      got_i = {out_dir, out_slot, out_idx, out_data};
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7/R8", "unexpected output item", got_i, 0);
      end else begin
        exp_i = exp_q.pop_front();
        req_s = req_q.pop_front();
        chk(got_i == exp_i, req_s, "output item", got_i, exp_i);
      end
    end
  end

  task automatic expect_out(input string req, input logic [1:0] d,
                            input logic [2:0] s, input logic i,
                            input logic [15:0] v);
    exp_q.push_back({d, s, i, v});
    req_q.push_back(req);
  endtask

  task automatic step();
    @(negedge clk);
    ld_en  = 1'b0;
    in_vld = '0;
    flush  = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) step();
  endtask

  task automatic load(input int slot, input int op, input int dir,
                      input int ts, input int ti);
    ld_en    = 1'b1;
    ld_slot  = 3'(slot);
    ld_op    = 3'(op);
    ld_dir   = 3'(dir);
    ld_tslot = 3'(ts);
    ld_tidx  = 1'(ti);
    step();
  endtask

  task automatic put(input int p, input int slot, input int idx,
                     input logic [15:0] v);
    in_vld[p]         = 1'b1;
    in_slot[p*3 +: 3] = 3'(slot);
    in_idx[p]         = 1'(idx);
    in_data[p*16 +: 16] = v;
  endtask

  task automatic drained(input string req);
    idle(3);
    chk(exp_q.size() == 0, req, "expected items left", exp_q.size(), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; ld_en = 1'b0; flush = 1'b0; out_rdy = 1'b1;
    ld_slot = '0; ld_op = '0; ld_dir = '0; ld_tslot = '0; ld_tidx = 1'b0;
    in_vld = '0; in_slot = '0; in_idx = '0; in_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(out_vld == 1'b0, "R1", "out_vld after reset", out_vld, 0);
    chk(err == 1'b0, "R1", "err after reset", err, 0);
    idle(2);
    chk(out_vld == 1'b0, "R1", "no issue while unloaded", out_vld, 0);

    // R2 R3 R7: both operands in one cycle, issue one cycle later
    load(0, 0, 1, 3, 1);
    put(0, 0, 0, 16'd5);
    put(1, 0, 1, 16'd7);
    expect_out("R3", 2'd1, 3'd3, 1'b1, 16'd12);
    step();
    chk(out_vld == 1'b0, "R3", "out_vld in operand cycle", out_vld, 0);
    step();
    chk(out_vld == 1'b1, "R3", "out_vld one cycle later", out_vld, 1);
    drained("R7");

    // R6: two slots complete together, lower slot first
    load(1, 1, 0, 2, 0);
    load(4, 3, 3, 5, 1);
    put(0, 1, 0, 16'd20);
    put(1, 4, 0, 16'h00F0);
    step();
    put(2, 1, 1, 16'd6);
    put(3, 4, 1, 16'h000F);
    expect_out("R6", 2'd0, 3'd2, 1'b0, 16'd14);
    expect_out("R6", 2'd3, 3'd5, 1'b1, 16'h00FF);
    step();
    drained("R6");

    // R4 R5: every opcode, single-operand ones fed only A
    for (int op = 0; op < 8; op++) begin
      load(7, op, 2, op, 0);
      put(3, 7, 0, 16'hA5C3);
      if (op != 5 && op != 7) put(2, 7, 1, 16'h0005);
      expect_out((op == 5 || op == 7) ? "R5" : "R4", 2'd2, 3'(op), 1'b0,
                 ref_alu(op, 16'hA5C3, 16'h0005));
      step();
      drained("R4");
    end

    // R8: local bypass to a consumer already holding operand B
    load(2, 5, 4, 5, 0);
    load(5, 4, 2, 1, 1);
    put(3, 5, 1, 16'd3);
    step();
    put(0, 2, 0, 16'd9);
    expect_out("R8", 2'd2, 3'd1, 1'b1, 16'd10);
    step();
    chk(out_vld == 1'b0, "R8", "out_vld after producer operand", out_vld, 0);
    step();
    chk(out_vld == 1'b0, "R8", "bypass result kept off port", out_vld, 0);
    step();
    chk(out_vld == 1'b1, "R8", "consumer result on port", out_vld, 1);
    chk(out_data == 16'd10, "R8", "consumer data", out_data, 10);
    drained("R8");

    // R9: stall with two pending results
    out_rdy = 1'b0;
    load(0, 2, 1, 0, 0);
    load(3, 0, 0, 1, 1);
    put(0, 0, 0, 16'h0FF0);
    put(1, 0, 1, 16'h00FF);
    put(2, 3, 0, 16'd100);
    put(3, 3, 1, 16'd23);
    expect_out("R9", 2'd1, 3'd0, 1'b0, 16'h00F0);
    expect_out("R9", 2'd0, 3'd1, 1'b1, 16'd123);
    step();
    step();
    idle(5);
    chk(out_vld == 1'b1, "R9", "held out_vld", out_vld, 1);
    chk(out_data == 16'h00F0, "R9", "held out_data", out_data, 16'h00F0);
    chk(exp_q.size() == 2, "R9", "nothing accepted while stalled", exp_q.size(), 2);
    out_rdy = 1'b1;
    drained("R9");
    chk(err == 1'b0, "R10", "err before late operand", err, 0);

    // R10: operand to a fired slot
    put(0, 0, 0, 16'd77);
    step();
    idle(3);
    chk(err == 1'b1, "R10", "err after late operand", err, 1);
    chk(out_vld == 1'b0, "R10", "no re-issue of fired slot", out_vld, 0);
    drained("R10");

    // R11: flush drops a partial operand and one arriving with it
    load(6, 1, 3, 2, 0);
    put(0, 6, 0, 16'd50);
    step();
    flush = 1'b1;
    put(1, 6, 1, 16'd8);
    step();
    put(0, 6, 0, 16'd60);
    step();
    idle(3);
    chk(out_vld == 1'b0, "R11", "no issue after flush with only A", out_vld, 0);
    put(0, 6, 1, 16'd10);
    put(1, 0, 0, 16'h003C);
    put(2, 0, 1, 16'h000F);
    expect_out("R11", 2'd1, 3'd0, 1'b0, 16'h000C);
    expect_out("R11", 2'd3, 3'd2, 1'b0, 16'd50);
    step();
    drained("R11");
    chk(err == 1'b1, "R10", "err survives flush", err, 1);

    // R11: flush discards a held result
    out_rdy = 1'b0;
    put(0, 3, 0, 16'd1);
    put(1, 3, 1, 16'd2);
    step();
    step();
    chk(out_vld == 1'b1, "R11", "result held before flush", out_vld, 1);
    flush = 1'b1;
    step();
    chk(out_vld == 1'b0, "R11", "held result dropped by flush", out_vld, 0);
    out_rdy = 1'b1;
    drained("R11");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule